// File: doc/BRIEF.md
# SIMD Single-Structure Load/Store Decoder

This block is a purely combinational decoder for one 32-bit instruction word taken from the SIMD single-structure load/store class. It handles both addressing forms of that class. In the no-offset form the base register is used as it stands. In the post-index form the base is updated afterwards, either by a register or by an immediate.

From the word the block pulls out the first destination register, the base register and the offset register. It then works out the structure shape: element scale, element count and lane index. It also reports whether the operation loads one element and replicates it to every lane, and whether the vector is 64 or 128 bits wide. For the writeback path it gives the writeback flag, the offset kind, the post-index immediate and the tag-check flag. Combinations that the class reserves raise an undefined flag.

All results go to a separate execution sequencer. That sequencer steps through the structure's elements. It reads and writes the register file and issues the memory accesses.

Top module: `simd_ldst_dec`

## Requirements
- R1: `vt_idx` equals bits 4:0, `base_idx` equals bits 9:5 and `off_idx` equals bits 20:16 of `instr`.
- R2: `elem_cnt` equals the two-bit value {bit 13, bit 21} plus one, so it lies between 1 and 4.
- R3: When bits 15:14 are 11, bit 22 is 1 and bit 12 is 0, `replicate` is 1, `scale` equals the size field in bits 11:10, and `lane_idx` is 0.
- R4: When bits 15:14 are 11 and either bit 22 is 0 or bit 12 is 1, `undef` is 1.
- R5: When bits 15:14 are 00, `scale` is 0 and `lane_idx` is {bit 30, bit 12, bits 11:10}, a value from 0 to 15.
- R6: When bits 15:14 are 01, `undef` is 1 if bit 10 is 1. Otherwise `scale` is 1 and `lane_idx` is {bit 30, bit 12, bit 11}.
- R7: When bits 15:14 are 10, `undef` is 1 if bit 11 is 1. If bits 11:10 are 00, `scale` is 2 and `lane_idx` is {bit 30, bit 12}. If bits 11:10 are 01, `undef` is 1 when bit 12 is 1; otherwise `scale` is 3 and `lane_idx` is bit 30.
- R8: `vec128` equals bit 30, and `esize_bits` equals 8 shifted left by `scale`.
- R9: `wback` equals bit 23. `use_imm` is 1 only when bit 23 is 1 and bits 20:16 are 31. `use_reg` is 1 only when bit 23 is 1 and bits 20:16 are not 31.
- R10: When `wback` is 1 and `undef` is 0, `post_imm` equals `elem_cnt` times 2 to the power of `scale`. For four-element replicate this gives 4, 8, 16 and 32 for sizes 0 to 3. In every other case `post_imm` is 0.
- R11: `tag_chk` is 1 when `wback` is 1 or `base_idx` is not 31, and is 0 otherwise.
- R12: While `undef` is 1, `lane_idx`, `scale`, `replicate` and `post_imm` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| vt_idx | output | 5 | First vector register of the list |
| base_idx | output | 5 | Base address register |
| off_idx | output | 5 | Post-index offset register field |
| elem_cnt | output | 3 | Elements per structure, 1 to 4 |
| scale | output | 2 | log2 of element bytes |
| esize_bits | output | 7 | Element size in bits |
| lane_idx | output | 4 | Lane accessed by a single-lane operation |
| replicate | output | 1 | Load one element and fill every lane |
| vec128 | output | 1 | Vector width is 128 bits (otherwise 64) |
| wback | output | 1 | Base register is written back |
| use_imm | output | 1 | Post-index amount is the immediate |
| use_reg | output | 1 | Post-index amount comes from a register |
| post_imm | output | 6 | Post-index immediate in bytes |
| tag_chk | output | 1 | Access is tag checked |
| undef | output | 1 | Reserved encoding |

## Verification
Directed words cover every combination of the two-bit scale with the size field, bit 12 and bit 22. These words separate the four lane-index formats from the reserved cases, and they separate the double-word remap from the word case. Post-index words with the offset field equal to 31 and to other values separate the immediate path from the register path. The four-element replicate words tie `post_imm` to the values 4, 8, 16 and 32. Base fields of 31 and of other values exercise the tag-check rule. Thousands of random words then exercise every field at once against an independent reference model, which catches cross-talk between fields that the directed words might miss.

// File: rtl/simd_ldst_pkg.sv
package simd_ldst_pkg;
  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 5;
  localparam int CNT_W   = 3;
  localparam int LANE_W  = 4;
  localparam int SCL_W   = 2;
  localparam int ESZ_W   = 7;
  localparam int IMM_W   = 6;
  localparam logic [RIDX_W-1:0] ZR_IDX = '1;

  typedef struct packed {
    logic              q;
    logic              post;
    logic              l;
    logic              r;
    logic [RIDX_W-1:0] rm;
    logic [2:0]        op;
    logic              s;
    logic [1:0]        sz;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
  } ldst_fields_t;
endpackage

// File: rtl/sld_field_split.sv
module sld_field_split
  import simd_ldst_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ldst_fields_t       fld
);
  always_comb begin
    fld.q    = instr[30];
    fld.post = instr[23];
    fld.l    = instr[22];
    fld.r    = instr[21];
    fld.rm   = instr[20:16];
    fld.op   = instr[15:13];
    fld.s    = instr[12];
    fld.sz   = instr[11:10];
    fld.rn   = instr[9:5];
    fld.rt   = instr[4:0];
  end
endmodule

// File: rtl/sld_elem_decode.sv
module sld_elem_decode
  import simd_ldst_pkg::*;
(
  input  ldst_fields_t      fld,
  output logic [CNT_W-1:0]  elem_cnt,
  output logic [SCL_W-1:0]  scale,
  output logic [LANE_W-1:0] lane_idx,
  output logic              replicate,
  output logic              undef
);
  logic [SCL_W-1:0]  scl_raw;
  logic [SCL_W-1:0]  scl_nxt;
  logic [LANE_W-1:0] lane_nxt;
  logic              rep_nxt;
  logic              und_nxt;

  assign scl_raw  = fld.op[2:1];
  assign elem_cnt = CNT_W'({fld.op[0], fld.r}) + CNT_W'(1);

  always_comb begin
    scl_nxt  = scl_raw;
    lane_nxt = '0;
    rep_nxt  = 1'b0;
    und_nxt  = 1'b0;
    unique case (scl_raw)
      2'b11: begin
        if (!fld.l || fld.s) begin
          und_nxt = 1'b1;
        end else begin
          scl_nxt = fld.sz;
          rep_nxt = 1'b1;
        end
      end
      2'b00: lane_nxt = {fld.q, fld.s, fld.sz};
      2'b01: begin
        if (fld.sz[0]) und_nxt = 1'b1;
        else lane_nxt = {1'b0, fld.q, fld.s, fld.sz[1]};
      end
      default: begin
        if (fld.sz[1]) begin
          und_nxt = 1'b1;
        end else if (!fld.sz[0]) begin
          lane_nxt = {2'b00, fld.q, fld.s};
        end else if (fld.s) begin
          und_nxt = 1'b1;
        end else begin
          lane_nxt = {3'b000, fld.q};
          scl_nxt  = 2'b11;
        end
      end
    endcase
  end

  always_comb begin
    undef     = und_nxt;
    scale     = und_nxt ? '0 : scl_nxt;
    lane_idx  = und_nxt ? '0 : lane_nxt;
    replicate = und_nxt ? 1'b0 : rep_nxt;
  end
endmodule

// File: rtl/sld_offset_decode.sv
module sld_offset_decode
  import simd_ldst_pkg::*;
(
  input  logic              post,
  input  logic [RIDX_W-1:0] rm,
  input  logic [RIDX_W-1:0] rn,
  input  logic [CNT_W-1:0]  elem_cnt,
  input  logic [SCL_W-1:0]  scale,
  input  logic              undef,
  output logic              wback,
  output logic              use_imm,
  output logic              use_reg,
  output logic [IMM_W-1:0]  post_imm,
  output logic              tag_chk
);
  logic             rm_is_zr;
  logic [IMM_W-1:0] struct_bytes;

  assign rm_is_zr     = (rm == ZR_IDX);
  assign struct_bytes = IMM_W'(elem_cnt) << scale;

  always_comb begin
    wback    = post;
    use_imm  = post && rm_is_zr;
    use_reg  = post && !rm_is_zr;
    post_imm = (post && !undef) ? struct_bytes : '0;
    tag_chk  = post || (rn != ZR_IDX);
  end
endmodule

// File: rtl/simd_ldst_dec.sv
module simd_ldst_dec
  import simd_ldst_pkg::*;
(
  input  logic [31:0] instr,
  output logic [4:0]  vt_idx,
  output logic [4:0]  base_idx,
  output logic [4:0]  off_idx,
  output logic [2:0]  elem_cnt,
  output logic [1:0]  scale,
  output logic [6:0]  esize_bits,
  output logic [3:0]  lane_idx,
  output logic        replicate,
  output logic        vec128,
  output logic        wback,
  output logic        use_imm,
  output logic        use_reg,
  output logic [5:0]  post_imm,
  output logic        tag_chk,
  output logic        undef
);
  ldst_fields_t fld;

  sld_field_split u_split (
    .instr (instr),
    .fld   (fld)
  );

  sld_elem_decode u_elem (
    .fld       (fld),
    .elem_cnt  (elem_cnt),
    .scale     (scale),
    .lane_idx  (lane_idx),
    .replicate (replicate),
    .undef     (undef)
  );

  sld_offset_decode u_off (
    .post     (fld.post),
    .rm       (fld.rm),
    .rn       (fld.rn),
    .elem_cnt (elem_cnt),
    .scale    (scale),
    .undef    (undef),
    .wback    (wback),
    .use_imm  (use_imm),
    .use_reg  (use_reg),
    .post_imm (post_imm),
    .tag_chk  (tag_chk)
  );

  assign vt_idx     = fld.rt;
  assign base_idx   = fld.rn;
  assign off_idx    = fld.rm;
  assign vec128     = fld.q;
  assign esize_bits = ESZ_W'(8) << scale;
endmodule

// File: rtl/simd_ldst_dec_chk.sv
module simd_ldst_dec_chk (
  input logic [4:0] base_idx,
  input logic [2:0] elem_cnt,
  input logic [1:0] scale,
  input logic [3:0] lane_idx,
  input logic       replicate,
  input logic       wback,
  input logic       use_imm,
  input logic       use_reg,
  input logic [5:0] post_imm,
  input logic       tag_chk,
  input logic       undef
);
  always_comb begin
    // R2
    cnt_range_chk: assert (elem_cnt >= 3'd1 && elem_cnt <= 3'd4);
    // R3
    rep_lane_zero_chk: assert (!replicate || lane_idx == 4'd0);
    // R6
    half_lane_chk: assert (undef || replicate || scale != 2'd1 || lane_idx < 4'd8);
    // R7
    dword_lane_chk: assert (undef || replicate || scale != 2'd3 || lane_idx < 4'd2);
    // R9
    offset_kind_chk: assert (!(use_imm && use_reg) && ((use_imm || use_reg) == wback));
    // R11
    tag_base_chk: assert (base_idx == 5'd31 || tag_chk);
    // R12
    undef_quiet_chk: assert (!undef || (!replicate && lane_idx == 4'd0 && post_imm == 6'd0));
  end
endmodule

bind simd_ldst_dec simd_ldst_dec_chk u_chk (
  .base_idx  (base_idx),
  .elem_cnt  (elem_cnt),
  .scale     (scale),
  .lane_idx  (lane_idx),
  .replicate (replicate),
  .wback     (wback),
  .use_imm   (use_imm),
  .use_reg   (use_reg),
  .post_imm  (post_imm),
  .tag_chk   (tag_chk),
  .undef     (undef)
);

// File: tb/simd_ldst_dec_bench.sv
module simd_ldst_dec_bench;
  logic clk;
  logic rst_n;
  logic [31:0] instr;
  logic [4:0]  vt_idx, base_idx, off_idx;
  logic [2:0]  elem_cnt;
  logic [1:0]  scale;
  logic [6:0]  esize_bits;
  logic [3:0]  lane_idx;
  logic        replicate, vec128, wback, use_imm, use_reg, tag_chk, undef;
  logic [5:0]  post_imm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] w;
    logic [4:0]  rt, rn, rm;
    logic [2:0]  cnt;
    logic [1:0]  scl;
    logic [6:0]  esz;
    logic [3:0]  lane;
    logic        rep, q, wb, ui, ur, tc, ud;
    logic [5:0]  imm;
  } exp_t;

  exp_t sb[$];

  simd_ldst_dec u_simd_ldst_dec (
    .instr(instr), .vt_idx(vt_idx), .base_idx(base_idx), .off_idx(off_idx),
    .elem_cnt(elem_cnt), .scale(scale), .esize_bits(esize_bits),
    .lane_idx(lane_idx), .replicate(replicate), .vec128(vec128),
    .wback(wback), .use_imm(use_imm), .use_reg(use_reg),
    .post_imm(post_imm), .tag_chk(tag_chk), .undef(undef)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    int sc, cnt, sz, ln;
    bit ud, rep;
    e.w = w;
    e.rt = w[4:0]; e.rn = w[9:5]; e.rm = w[20:16];
    cnt = 1 + 2 * int'(w[13]) + int'(w[21]);
    sz = int'(w[11:10]);
    sc = int'(w[15:14]);
    ud = 0; rep = 0; ln = 0;
    if (sc == 3) begin
      if (w[22] == 1'b0 || w[12] == 1'b1) ud = 1;
      else begin rep = 1; sc = sz; end
    end else if (sc == 0) begin
      ln = 8 * int'(w[30]) + 4 * int'(w[12]) + sz;
    end else if (sc == 1) begin
      if (w[10]) ud = 1;
      else ln = 4 * int'(w[30]) + 2 * int'(w[12]) + int'(w[11]);
    end else begin
      if (sz == 0) ln = 2 * int'(w[30]) + int'(w[12]);
      else if (sz == 1 && !w[12]) begin ln = int'(w[30]); sc = 3; end
      else ud = 1;
    end
    if (ud) begin sc = 0; ln = 0; rep = 0; end
    e.cnt = 3'(cnt); e.scl = 2'(sc); e.lane = 4'(ln); e.rep = rep; e.ud = ud;
    e.esz = 7'(8 * (1 << sc));
    e.q = w[30];
    e.wb = w[23];
    e.ui = w[23] && (w[20:16] == 5'd31);
    e.ur = w[23] && (w[20:16] != 5'd31);
    e.imm = (w[23] && !ud) ? 6'(cnt * (1 << sc)) : 6'd0;
    e.tc = w[23] || (w[9:5] != 5'd31);
    return e;
  endfunction

  function automatic logic [31:0] mk(input bit q, input bit post, input bit l, input bit r,
                                     input logic [4:0] rm, input logic [2:0] op, input bit s,
                                     input logic [1:0] sz, input logic [4:0] rn,
                                     input logic [4:0] rt);
    return {1'b0, q, 6'b001101, post, l, r, rm, op, s, sz, rn, rt};
  endfunction

  task automatic drive(input logic [31:0] w);
    @(posedge clk);
    instr <= w;
    sb.push_back(model(w));
  endtask

  task automatic cmp(input string req, input string name, input int act, input int expv,
                     input logic [31:0] w);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s instr=%h actual=%0d expected=%0d", req, name, w, act, expv);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && sb.size() > 0) begin
        e = sb.pop_front();
        cmp("R1", "vt_idx", vt_idx, e.rt, e.w);
        cmp("R1", "base_idx", base_idx, e.rn, e.w);
        cmp("R1", "off_idx", off_idx, e.rm, e.w);
        cmp("R2", "elem_cnt", elem_cnt, e.cnt, e.w);
        cmp("R3", "replicate", replicate, e.rep, e.w);
        cmp("R4", "undef", undef, e.ud, e.w);
        cmp("R5", "scale", scale, e.scl, e.w);
        cmp("R6", "lane_idx", lane_idx, e.lane, e.w);
        cmp("R8", "vec128", vec128, e.q, e.w);
        cmp("R8", "esize_bits", esize_bits, e.esz, e.w);
        cmp("R9", "wback", wback, e.wb, e.w);
        cmp("R9", "use_imm", use_imm, e.ui, e.w);
        cmp("R9", "use_reg", use_reg, e.ur, e.w);
        cmp("R10", "post_imm", post_imm, e.imm, e.w);
        cmp("R11", "tag_chk", tag_chk, e.tc, e.w);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0;
    instr = 32'd0;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    // reset-state word (all zero fields)
    drive(32'd0);
    // R3 R10: four-element replicate, post-index immediate, all sizes
    for (int z = 0; z < 4; z++) drive(mk(1, 1, 1, 1, 5'd31, 3'b111, 0, 2'(z), 5'd3, 5'd30));
    // R4: replicate reserved (L=0, S=1)
    drive(mk(0, 0, 0, 1, 5'd0, 3'b110, 0, 2'd1, 5'd2, 5'd1));
    drive(mk(1, 1, 1, 0, 5'd31, 3'b111, 1, 2'd2, 5'd2, 5'd1));
    // R5 R6 R7: every scale, size and S combination, both widths
    for (int sc = 0; sc < 3; sc++)
      for (int z = 0; z < 4; z++)
        for (int sb_ = 0; sb_ < 2; sb_++)
          for (int qq = 0; qq < 2; qq++)
            drive(mk(qq[0], 1, 1, sb_[0], 5'd7, {2'(sc), 1'b1}, sb_[0], 2'(z), 5'd4, 5'd5));
    // R9 R11: register offset, no offset, base 31
    drive(mk(0, 1, 1, 0, 5'd9, 3'b000, 0, 2'd0, 5'd31, 5'd0));
    drive(mk(0, 0, 1, 0, 5'd0, 3'b000, 0, 2'd0, 5'd31, 5'd0));
    drive(mk(1, 0, 0, 0, 5'd0, 3'b100, 0, 2'd1, 5'd30, 5'd31));
    // R12: reserved with post-index must give zero immediate
    drive(mk(1, 1, 1, 1, 5'd31, 3'b011, 0, 2'd3, 5'd1, 5'd1));
    // random words
    for (int i = 0; i < 3000; i++) drive($urandom());
    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule